// File: doc/BRIEF.md
# DMA Controller Command, Mask and Status Port Block

This block is the controller-level register file of a four-channel DMA controller. It takes single-byte host writes and reads on an I/O address window and holds the command byte, the four-bit channel mask, the eight-bit status byte and one mode byte per channel. The transfer engine and the per-channel logic read the mask, the request flags and the decoded mode fields from its outputs. The block also emits a one-cycle strobe that clears the byte-pointer flip-flop, which lives in the channel register block.

The status byte is shared by several sources. The upper nibble holds one request flag per channel. Software sets and clears these flags through the request port, and external agents set and clear them through hold and release inputs. The lower nibble holds one terminal-count flag per channel, which the transfer engine sets. Command features that the controller does not implement are not carried out. Writing one of them sets a sticky flag that the system can observe.

The window starts at `BASE + (8 << SHIFT)` and covers `8 << SHIFT` bytes. The port index is the byte offset into this window shifted right by `SHIFT`. With `SHIFT = 1`, the block serves a controller on a 16-bit stride, so odd addresses alias the even address below them.

Top module: `dma_ctl_regs`

## Requirements
- R1: After the asynchronous reset, the block holds these values: command 0x00, status 0x00, mask 0xF, all mode bytes 0x00, unsupported flag 0, and flip-flop strobe 0.
- R2: An access hits only when its address is inside [BASE+(8<<SHIFT), BASE+(16<<SHIFT)). The port number is (address - window start) >> SHIFT. A write outside the window changes nothing.
- R3: A write to port 0 stores the byte as the command. If the byte is nonzero and has any of bits 0,1,3,4,5,6,7 set (mask 0xFB), the sticky unsupported flag is set. A byte of 0x00 or 0x04 leaves the flag unchanged.
- R4: On a write to port 1, ch = data[1:0]. Status bit ch+4 is loaded with data[2], and status bit ch is cleared.
- R5: On a write to port 2, ch = data[1:0], and mask bit ch is loaded with data[2].
- R6: On a write to port 3, the whole byte is stored as the mode of channel data[1:0]. Each channel's decoded outputs come from its mode byte: auto-initialise is bit 4, address decrement is bit 5, verify is high when bits 3:2 are 00, and the operating mode is bits 7:6.
- R7: A write to port 4 makes the flip-flop strobe high for exactly the next cycle.
- R8: A write to port 5 clears command, status and the unsupported flag, sets all mask bits and pulses the flip-flop strobe. The mode bytes are kept. It overrides any external status event in the same cycle.
- R9: A write to port 6 clears all mask bits. A write to port 7 loads the mask from data[3:0].
- R10: The read data is combinational and is zero unless a read hits. A read of port 0 returns status, and a read of port 1 returns {4'b0, mask}. Every other port reads 0.
- R11: A hold pulse on channel i sets status bit i+4, and a release pulse clears it. If both arrive in the same cycle, release wins. These external events apply after a same-cycle request-port write.
- R12: A terminal-count pulse on channel i sets status bit i. It applies after a same-cycle request-port write, so the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| addr | input | ADDR_W | Host I/O address |
| wdata | input | 8 | Host write byte |
| rdata | output | 8 | Host read byte |
| dreq_hold | input | 4 | Per-channel external request set pulses |
| dreq_rel | input | 4 | Per-channel external request clear pulses |
| tc_set | input | 4 | Per-channel terminal-count pulses from the transfer engine |
| cmd_o | output | 8 | Command byte |
| unsup_o | output | 1 | Sticky unsupported-command flag |
| mask_o | output | 4 | Channel mask |
| req_o | output | 4 | Request flags (status bits 7:4) |
| tc_o | output | 4 | Terminal-count flags (status bits 3:0) |
| mode_o | output | 32 | Four mode bytes, channel i in bits 8i+7:8i |
| autoinit_o | output | 4 | Per-channel auto-initialise enable |
| decr_o | output | 4 | Per-channel address decrement |
| verify_o | output | 4 | Per-channel verify operation |
| ff_clr_o | output | 1 | One-cycle flip-flop clear strobe |

## Verification
The bench builds the block with BASE = 0xC0 and SHIFT = 1, so the controller window runs from 0xD0 to 0xDF. These values exercise three address behaviours. Odd addresses must alias their even port. Addresses just below the window (the channel group at 0xC0) must be ignored. The address one byte past the window must also be ignored. A behavioural model predicts every output on every clock. The stimulus includes same-cycle collisions between request-port writes, hold, release, terminal-count pulses and master reset.

// File: rtl/dma_ctl_regs.sv
module dma_ctl_regs #(
  parameter int ADDR_W = 16,
  parameter int BASE   = 0,
  parameter int SHIFT  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic [3:0]        dreq_hold,
  input  logic [3:0]        dreq_rel,
  input  logic [3:0]        tc_set,
  output logic [7:0]        cmd_o,
  output logic              unsup_o,
  output logic [3:0]        mask_o,
  output logic [3:0]        req_o,
  output logic [3:0]        tc_o,
  output logic [31:0]       mode_o,
  output logic [3:0]        autoinit_o,
  output logic [3:0]        decr_o,
  output logic [3:0]        verify_o,
  output logic              ff_clr_o
);
  localparam int NCH = 4;
  localparam logic [ADDR_W-1:0] WIN_START = ADDR_W'(BASE + (8 << SHIFT));
  localparam logic [ADDR_W-1:0] WIN_SIZE  = ADDR_W'(8 << SHIFT);
  localparam logic [7:0] UNSUP_BITS = 8'hFB;

  logic [ADDR_W-1:0] off;
  logic              hit;
  logic [2:0]        port;
  logic [1:0]        ch;

  assign off  = addr - WIN_START;
  assign hit  = off < WIN_SIZE;
  assign port = off[SHIFT+2:SHIFT];
  assign ch   = wdata[1:0];

  logic wr_cmd, wr_req, wr_smask, wr_mode, wr_ffc, wr_mrst, wr_clrm, wr_allm;
  assign wr_cmd   = wr_en && hit && port == 3'd0;
  assign wr_req   = wr_en && hit && port == 3'd1;
  assign wr_smask = wr_en && hit && port == 3'd2;
  assign wr_mode  = wr_en && hit && port == 3'd3;
  assign wr_ffc   = wr_en && hit && port == 3'd4;
  assign wr_mrst  = wr_en && hit && port == 3'd5;
  assign wr_clrm  = wr_en && hit && port == 3'd6;
  assign wr_allm  = wr_en && hit && port == 3'd7;

  logic [7:0] cmd_q, status_q, status_n;
  logic [3:0] mask_q;
  logic       unsup_q, ff_q;
  logic [7:0] mode_q [NCH];

  always_comb begin
    status_n = status_q;
    if (wr_req) begin
      status_n[{1'b1, ch}] = wdata[2];
      status_n[{1'b0, ch}] = 1'b0;
    end
    status_n[7:4] = (status_n[7:4] | dreq_hold) & ~dreq_rel;
    status_n[3:0] = status_n[3:0] | tc_set;
    if (wr_mrst) status_n = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q    <= '0;
      status_q <= '0;
      mask_q   <= '1;
      unsup_q  <= 1'b0;
      ff_q     <= 1'b0;
    end else begin
      status_q <= status_n;
      ff_q     <= wr_ffc || wr_mrst;
      if (wr_mrst) begin
        cmd_q   <= '0;
        unsup_q <= 1'b0;
        mask_q  <= '1;
      end else begin
        if (wr_cmd) begin
          cmd_q <= wdata;
          if ((wdata & UNSUP_BITS) != 8'h00) unsup_q <= 1'b1;
        end
        if (wr_smask) mask_q[ch] <= wdata[2];
        if (wr_clrm)  mask_q <= '0;
        if (wr_allm)  mask_q <= wdata[3:0];
      end
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_mode
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          mode_q[i] <= '0;
      else if (wr_mode && ch == 2'(i))     mode_q[i] <= wdata;
    end
    assign mode_o[8*i +: 8] = mode_q[i];
    assign autoinit_o[i]    = mode_q[i][4];
    assign decr_o[i]        = mode_q[i][5];
    assign verify_o[i]      = mode_q[i][3:2] == 2'b00;
  end

  always_comb begin
    rdata = '0;
    if (rd_en && hit) begin
      if (port == 3'd0)      rdata = status_q;
      else if (port == 3'd1) rdata = {4'b0, mask_q};
    end
  end

  assign cmd_o    = cmd_q;
  assign unsup_o  = unsup_q;
  assign mask_o   = mask_q;
  assign req_o    = status_q[7:4];
  assign tc_o     = status_q[3:0];
  assign ff_clr_o = ff_q;
endmodule

// File: rtl/dma_ctl_regs_chk.sv
module dma_ctl_regs_chk #(
  parameter int ADDR_W = 16,
  parameter int BASE   = 0,
  parameter int SHIFT  = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        wdata,
  input logic [7:0]        rdata,
  input logic [3:0]        dreq_hold,
  input logic [3:0]        dreq_rel,
  input logic [3:0]        tc_set,
  input logic [3:0]        mask_o,
  input logic [3:0]        req_o,
  input logic [3:0]        tc_o,
  input logic [31:0]       mode_o,
  input logic              ff_clr_o
);
  localparam logic [ADDR_W-1:0] WS = ADDR_W'(BASE + (8 << SHIFT));
  localparam logic [ADDR_W-1:0] WZ = ADDR_W'(8 << SHIFT);
  logic [ADDR_W-1:0] o;
  logic in_win;
  logic [2:0] p;
  assign o      = addr - WS;
  assign in_win = o < WZ;
  assign p      = o[SHIFT+2:SHIFT];

  a_r8_master_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && in_win && p == 3'd5) |=> (mask_o == 4'hF && req_o == 4'h0 && tc_o == 4'h0 && ff_clr_o));

  a_r5_single_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && in_win && p == 3'd2) |=> (mask_o[$past(wdata[1:0])] == $past(wdata[2])));

  a_r12_tc_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_set != 4'h0 && !(wr_en && in_win && p == 3'd5)) |=> ((tc_o & $past(tc_set)) == $past(tc_set)));

  a_r11_release_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (dreq_rel != 4'h0) |=> ((req_o & $past(dreq_rel)) == 4'h0));

  a_r10_other_ports_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !(in_win && (p == 3'd0 || p == 3'd1))) |-> rdata == 8'h00);

  a_r7_strobe_cause: assert property (@(posedge clk) disable iff (!rst_n)
    ff_clr_o |-> $past(wr_en && in_win && (p == 3'd4 || p == 3'd5)));

  a_r2_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(mask_o) && $stable(mode_o)));
endmodule

bind dma_ctl_regs dma_ctl_regs_chk #(.ADDR_W(ADDR_W), .BASE(BASE), .SHIFT(SHIFT)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
  .rdata(rdata), .dreq_hold(dreq_hold), .dreq_rel(dreq_rel), .tc_set(tc_set),
  .mask_o(mask_o), .req_o(req_o), .tc_o(tc_o), .mode_o(mode_o), .ff_clr_o(ff_clr_o));

// File: tb/dma_ctl_regs_tb.sv
module dma_ctl_regs_tb_top;
  localparam int AW = 16;
  localparam int BASE = 'hC0;
  localparam int SHIFT = 1;
  localparam int WSTART = BASE + (8 << SHIFT);

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, rd_en = 0;
  logic [AW-1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [3:0] dreq_hold = '0, dreq_rel = '0, tc_set = '0;
  logic [7:0] rdata, cmd_o;
  logic unsup_o, ff_clr_o;
  logic [3:0] mask_o, req_o, tc_o, autoinit_o, decr_o, verify_o;
  logic [31:0] mode_o;

  always #10 clk = ~clk;

  dma_ctl_regs #(.ADDR_W(AW), .BASE(BASE), .SHIFT(SHIFT)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .dreq_hold(dreq_hold), .dreq_rel(dreq_rel), .tc_set(tc_set),
    .cmd_o(cmd_o), .unsup_o(unsup_o), .mask_o(mask_o), .req_o(req_o), .tc_o(tc_o),
    .mode_o(mode_o), .autoinit_o(autoinit_o), .decr_o(decr_o), .verify_o(verify_o),
    .ff_clr_o(ff_clr_o));

  int checks = 0, errors = 0;
  bit done = 0;

  int m_cmd, m_stat, m_mask, m_unsup, m_ff;
  int m_mode [4];

  function automatic int port_of(int a);
    int off = a - WSTART;
    if (off < 0 || off >= (8 << SHIFT)) return -1;
    return off >> SHIFT;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cmd = 0; m_stat = 0; m_mask = 15; m_unsup = 0; m_ff = 0;
      foreach (m_mode[k]) m_mode[k] = 0;
    end else begin
      int p, c, d;
      bit mr;
      p = wr_en ? port_of(int'(addr)) : -1;
      d = int'(wdata);
      c = d % 4;
      mr = (p == 5);
      m_ff = (p == 4 || p == 5);
      case (p)
        0: begin m_cmd = d; if ((d & 'hFB) != 0) m_unsup = 1; end
        1: begin
             if ((d / 4) % 2 == 1) m_stat = m_stat | (1 << (c + 4));
             else m_stat = m_stat & ~(1 << (c + 4));
             m_stat = m_stat & ~(1 << c);
           end
        2: begin
             if ((d / 4) % 2 == 1) m_mask = m_mask | (1 << c);
             else m_mask = m_mask & ~(1 << c);
           end
        3: m_mode[c] = d;
        6: m_mask = 0;
        7: m_mask = d % 16;
        default: ;
      endcase
      for (int i = 0; i < 4; i++) begin
        if (dreq_hold[i]) m_stat = m_stat | (1 << (i + 4));
        if (dreq_rel[i])  m_stat = m_stat & ~(1 << (i + 4));
        if (tc_set[i])    m_stat = m_stat | (1 << i);
      end
      if (mr) begin m_cmd = 0; m_stat = 0; m_unsup = 0; m_mask = 15; end
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    int p, er, ai, dc, vf;
    p = rd_en ? port_of(int'(addr)) : -1;
    er = (p == 0) ? m_stat : (p == 1) ? m_mask : 0;
    ai = 0; dc = 0; vf = 0;
    for (int i = 0; i < 4; i++) begin
      ai |= ((m_mode[i] >> 4) & 1) << i;
      dc |= ((m_mode[i] >> 5) & 1) << i;
      vf |= (((m_mode[i] >> 2) & 3) == 0 ? 1 : 0) << i;
    end
    chk("R3 command", int'(cmd_o), m_cmd);
    chk("R3 unsupported flag", int'(unsup_o), m_unsup);
    chk("R5 R9 mask", int'(mask_o), m_mask);
    chk("R4 R11 request flags", int'(req_o), m_stat >> 4);
    chk("R12 terminal count", int'(tc_o), m_stat % 16);
    chk("R6 mode bytes", int'(mode_o), (m_mode[3] << 24) | (m_mode[2] << 16) | (m_mode[1] << 8) | m_mode[0]);
    chk("R6 autoinit", int'(autoinit_o), ai);
    chk("R6 decrement", int'(decr_o), dc);
    chk("R6 verify", int'(verify_o), vf);
    chk("R7 R8 strobe", int'(ff_clr_o), m_ff);
    chk("R10 R2 read data", int'(rdata), er);
  end

  task automatic cyc(bit w, bit r, int a, int d, int h = 0, int rl = 0, int t = 0);
    @(negedge clk); #2;
    wr_en = w; rd_en = r; addr = AW'(a); wdata = 8'(d);
    dreq_hold = 4'(h); dreq_rel = 4'(rl); tc_set = 4'(t);
  endtask
  task automatic wp(int p, int d); cyc(1, 0, WSTART + 2 * p, d); endtask
  task automatic rp(int p); cyc(0, 1, WSTART + 2 * p, 0); endtask
  task automatic idle(); cyc(0, 0, 0, 0); endtask

  initial begin
    repeat (3) @(negedge clk);
    #2 rst_n = 1;
    idle(); idle();
    // R1 reset values
    chk("R1 reset mask", int'(mask_o), 15);
    chk("R1 reset status", int'({req_o, tc_o}), 0);
    // R3 command
    wp(0, 'h00); wp(0, 'h04); idle();
    chk("R3 0x04 no flag", int'(unsup_o), 0);
    wp(0, 'h10); idle();
    chk("R3 0x10 flags", int'(unsup_o), 1);
    wp(5, 0); idle();
    chk("R8 clears flag", int'(unsup_o), 0);
    foreach (m_mode[k]) ;
    for (int b = 0; b < 8; b++) begin wp(0, 1 << b); wp(5, 0); end
    // R6 modes
    wp(3, 'h00); wp(3, 'h59); wp(3, 'hA6); wp(3, 'h3F); idle();
    wp(3, 'h84); cyc(1, 0, WSTART + 2 * 3 + 1, 'h71); idle();
    // R5 single mask, R9 all masks
    for (int c = 0; c < 4; c++) wp(2, c);
    wp(2, 'h06); wp(7, 'hA5); idle(); wp(6, 0); wp(7, 'h0C); idle();
    // R4 request port
    wp(1, 'h05); wp(1, 'h07); wp(1, 'h01); idle();
    // R12 terminal count, collision with request write
    cyc(0, 0, 0, 0, 0, 0, 'hA);
    cyc(1, 0, WSTART + 2, 'h03, 0, 0, 'h8);
    cyc(1, 0, WSTART + 2, 'h02, 0, 0, 'h0);
    // R11 hold/release, release wins
    cyc(0, 0, 0, 0, 'h3, 0, 0);
    cyc(0, 0, 0, 0, 'h4, 'h6, 0);
    cyc(1, 0, WSTART + 2, 'h04, 0, 'h1, 0);
    cyc(1, 0, WSTART + 2, 'h01, 'h2, 0, 0);
    idle();
    // R10 reads
    rp(0); rp(1); rp(2); rp(3); rp(7);
    cyc(0, 1, WSTART + 1, 0); cyc(0, 1, WSTART + 3, 0);
    cyc(0, 1, BASE, 0); cyc(0, 1, WSTART + 16, 0);
    // R2 writes outside window ignored
    cyc(1, 0, BASE + 6, 'h00); cyc(1, 0, WSTART + 16, 'h00); cyc(1, 0, WSTART - 1, 'h00); idle();
    // R7 strobe, back to back
    wp(4, 0); idle(); wp(4, 0); wp(4, 0); idle(); idle();
    // R8 master reset beats hold and tc, modes kept
    cyc(0, 0, 0, 0, 'hF, 0, 'hF);
    cyc(1, 0, WSTART + 10, 0, 'hF, 0, 'hF);
    idle(); rp(0); rp(1);
    // R1 asynchronous reset mid-run
    wp(7, 3); wp(3, 'h12); idle();
    #3 rst_n = 0; #5 rst_n = 1;
    idle(); idle();
    chk("R1 mode after reset", int'(mode_o), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule